// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the datapath core for an 8-bit integer unit. It takes two byte operands, an incoming carry and a five-bit operation code. In the same cycle it produces a byte result, a six-bit vector of candidate flag values and a six-bit write mask. The mask marks the flags that the chosen operation is allowed to change.

A small registered status word sits behind this logic. While `en` is high, each rising clock edge loads the masked flags into it. Flags outside the mask keep their old values. A surrounding core can therefore either read the flag candidates directly or take the merged status word.

The flag vector layout is shared by `fl_new`, `fl_we` and `status`: bit 5 is H (carry or borrow out of bit 3), bit 4 is S (sign), bit 3 is V (signed overflow), bit 2 is N (negative), bit 1 is Z (zero) and bit 0 is C (carry or borrow).

Top module: `alu8_flags`

## Requirements
- R1: Codes 0 (add) and 1 (add plus `cin`) give `res` = (opa + opb [+ cin]) mod 256. C is the carry out of bit 7, H is the carry out of bit 3 and V is signed overflow. All six flags are written.
- R2: Codes 2 (subtract) and 3 (subtract minus `cin`) give `res` = (opa − opb [− cin]) mod 256. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow. All six flags are written.
- R3: Codes 4 (AND), 5 (OR) and 6 (XOR) write only S, V, N and Z, with V = 0. They leave C and H unchanged.
- R4: Code 7 gives `res` = 0xFF − opa. It writes S, V, N, Z and C, with C = 1 and V = 0. H is unchanged.
- R5: Code 8 gives `res` = 0x00 − opa, with the same six-flag rules as a subtraction from zero. In particular, C = 1 exactly when opa ≠ 0, and V = 1 exactly when opa = 0x80.
- R6: Code 9 (increment) and code 10 (decrement) write only S, V, N and Z. V is set on 0x7F→0x80 for increment and on 0x80→0x7F for decrement. C and H are unchanged.
- R7: Code 11 shifts left with a 0 inserted at bit 0, and code 12 shifts right with a 0 inserted at bit 7. C takes the bit shifted out, and V = N xor C. They write S, V, N, Z and C, and leave H unchanged.
- R8: Code 13 rotates left through carry: `cin` goes into bit 0 and old bit 7 goes into C. Code 14 rotates right through carry: `cin` goes into bit 7 and old bit 0 goes into C. Flag rules are as in R7.
- R9: Code 15 shifts right arithmetically: bit 7 is kept, C takes bit 0, and V = N xor C. Flag rules are as in R7.
- R10: Code 16 exchanges the two nibbles of opa, and code 17 yields 0xFF. Both have an all-zero write mask. Codes 18 to 31 yield 0 with an all-zero mask.
- R11: Whenever N or V is written, S = N xor V. Whenever Z is written, Z = 1 exactly when `res` is 0.
- R12: `status` resets to 0. On a rising edge with `en` high, each flag whose mask bit is set takes its new value and every other flag keeps its value. With `en` low, `status` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status word |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Commit the masked flags into `status` |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand (sole operand for one-operand codes) |
| opb | input | 8 | Second operand |
| cin | input | 1 | Incoming carry for add/subtract with carry and rotates |
| res | output | 8 | Combinational result |
| fl_new | output | 6 | Candidate flag values {H,S,V,N,Z,C} |
| fl_we | output | 6 | Flags the operation writes |
| status | output | 6 | Registered status word |

## Verification
The assertions assume that `op`, `opa`, `opb`, `cin` and `en` are stable around each rising edge. They also assume these inputs carry known values once reset is released; they make no assumption about operand ranges. The stimulus changes inputs only on falling edges and holds `en` low during reset. Beyond these rules the stimulus is unconstrained: it draws any code from 0 to 31, including the unused ones, and any operand and carry values. Directed cases are added at the overflow and borrow edges: 0x7F/0x80 and zero operands.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [4:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic       cin,
  output logic [7:0] res,
  output logic [5:0] fl_new,
  output logic [5:0] fl_we,
  output logic [5:0] status
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7;
  localparam logic [4:0] OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11;
  localparam logic [4:0] OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15;
  localparam logic [4:0] OP_SWP = 5'd16, OP_SET = 5'd17;

  localparam logic [5:0] WE_ALL   = 6'b111111;
  localparam logic [5:0] WE_SVNZ  = 6'b011110;
  localparam logic [5:0] WE_SVNZC = 6'b011111;

  logic [7:0] r, mn, sb;
  logic       c, v, h, fix_v0, nc_v;

  always_comb begin
    r      = '0;
    c      = 1'b0;
    v      = 1'b0;
    h      = 1'b0;
    mn     = opa;
    sb     = opb;
    fix_v0 = 1'b0;
    nc_v   = 1'b0;
    fl_we  = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        {c, r} = {1'b0, opa} + {1'b0, opb} + {8'b0, cin & (op == OP_ADC)};
        h = (opa[3] & opb[3]) | (opb[3] & ~r[3]) | (~r[3] & opa[3]);
        v = (opa[7] & opb[7] & ~r[7]) | (~opa[7] & ~opb[7] & r[7]);
        fl_we = WE_ALL;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        mn = (op == OP_NEG) ? 8'h00 : opa;
        sb = (op == OP_NEG) ? opa : opb;
        {c, r} = {1'b0, mn} - {1'b0, sb} - {8'b0, cin & (op == OP_SBC)};
        h = (~mn[3] & sb[3]) | (sb[3] & r[3]) | (r[3] & ~mn[3]);
        v = (mn[7] & ~sb[7] & ~r[7]) | (~mn[7] & sb[7] & r[7]);
        fl_we = WE_ALL;
      end
      OP_AND: begin r = opa & opb; fix_v0 = 1'b1; fl_we = WE_SVNZ; end
      OP_OR:  begin r = opa | opb; fix_v0 = 1'b1; fl_we = WE_SVNZ; end
      OP_XOR: begin r = opa ^ opb; fix_v0 = 1'b1; fl_we = WE_SVNZ; end
      OP_COM: begin r = ~opa; c = 1'b1; fix_v0 = 1'b1; fl_we = WE_SVNZC; end
      OP_INC: begin r = opa + 8'd1; v = (opa == 8'h7F); fl_we = WE_SVNZ; end
      OP_DEC: begin r = opa - 8'd1; v = (opa == 8'h80); fl_we = WE_SVNZ; end
      OP_LSL: begin r = {opa[6:0], 1'b0};   c = opa[7]; nc_v = 1'b1; fl_we = WE_SVNZC; end
      OP_LSR: begin r = {1'b0, opa[7:1]};   c = opa[0]; nc_v = 1'b1; fl_we = WE_SVNZC; end
      OP_ROL: begin r = {opa[6:0], cin};    c = opa[7]; nc_v = 1'b1; fl_we = WE_SVNZC; end
      OP_ROR: begin r = {cin, opa[7:1]};    c = opa[0]; nc_v = 1'b1; fl_we = WE_SVNZC; end
      OP_ASR: begin r = {opa[7], opa[7:1]}; c = opa[0]; nc_v = 1'b1; fl_we = WE_SVNZC; end
      OP_SWP: r = {opa[3:0], opa[7:4]};
      OP_SET: r = 8'hFF;
      default: r = '0;
    endcase
    if (fix_v0) v = 1'b0;
    if (nc_v)   v = r[7] ^ c;
  end

  assign res    = r;
  assign fl_new = {h, r[7] ^ v, v, r[7], (r == 8'h00), c};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  status <= '0;
    else if (en) status <= (status & ~fl_we) | (fl_new & fl_we);
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [4:0] op,
  input logic [7:0] opa,
  input logic [7:0] res,
  input logic [5:0] fl_new,
  input logic [5:0] fl_we,
  input logic [5:0] status
);
  assert_logic_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 5'd4 && op <= 5'd6) |-> (fl_we == 6'b011110 && !fl_new[3]));

  assert_incdec_keep_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd9 || op == 5'd10) |-> (!fl_we[0] && !fl_we[5]));

  assert_neg_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd8) |-> (fl_new[0] == (opa != 8'h00)));

  assert_quiet_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 5'd16) |-> (fl_we == 6'b000000));

  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we[1] |-> (fl_new[1] == (res == 8'h00)));

  assert_sign_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we[4] |-> (fl_new[4] == (fl_new[2] ^ fl_new[3])));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(status));

  assert_carry_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fl_we[0]) |=> (status[0] == $past(fl_new[0])));

  assert_carry_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fl_we[0]) |=> (status[0] == $past(status[0])));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa),
  .res(res), .fl_new(fl_new), .fl_we(fl_we), .status(status)
);

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic       cin = 1'b0;
  logic [7:0] res;
  logic [5:0] fl_new, fl_we, status;

  int n_cmp = 0, n_bad = 0;
  logic [5:0] mstat = '0;
  bit done = 0;

  typedef struct {
    logic [4:0] op;
    logic [7:0] r;
    logic [5:0] f, w, st;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
    .cin(cin), .res(res), .fl_new(fl_new), .fl_we(fl_we), .status(status)
  );

  function automatic string req_of(input logic [4:0] o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5, 6: return "R3";
      7: return "R4";
      8: return "R5";
      9, 10: return "R6";
      11, 12: return "R7";
      13, 14: return "R8";
      15: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // reference model: returns {res, flags, mask}
  function automatic logic [19:0] model(input logic [4:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic ci);
    int sa, sb, sr, u;
    logic [7:0] r = 0;
    logic c = 0, v = 0, h = 0;
    logic [5:0] w = 0, f;
    sa = $signed(a); sb = $signed(b);
    case (o)
      0, 1: begin
        u = int'(a) + int'(b) + ((o == 1 && ci) ? 1 : 0);
        r = u[7:0]; c = u > 255;
        h = (int'(a & 8'hF) + int'(b & 8'hF) + ((o == 1 && ci) ? 1 : 0)) > 15;
        sr = sa + sb + ((o == 1 && ci) ? 1 : 0); v = sr > 127 || sr < -128;
        w = 6'h3F;
      end
      2, 3, 8: begin
        logic [7:0] m, s; int k;
        m = (o == 8) ? 8'h00 : a; s = (o == 8) ? a : b;
        k = (o == 3 && ci) ? 1 : 0;
        u = int'(m) - int'(s) - k; r = u[7:0]; c = u < 0;
        h = int'(m & 8'hF) < int'(s & 8'hF) + k;
        sr = int'($signed(m)) - int'($signed(s)) - k; v = sr > 127 || sr < -128;
        w = 6'h3F;
      end
      4: begin r = a & b; w = 6'h1E; end
      5: begin r = a | b; w = 6'h1E; end
      6: begin r = a ^ b; w = 6'h1E; end
      7: begin r = 8'hFF - a; c = 1; w = 6'h1F; end
      9: begin r = a + 1; v = (a == 8'h7F); w = 6'h1E; end
      10: begin r = a - 1; v = (a == 8'h80); w = 6'h1E; end
      11: begin r = a << 1; c = a[7]; w = 6'h1F; end
      12: begin r = a >> 1; c = a[0]; w = 6'h1F; end
      13: begin r = (a << 1) | {7'b0, ci}; c = a[7]; w = 6'h1F; end
      14: begin r = (a >> 1) | {ci, 7'b0}; c = a[0]; w = 6'h1F; end
      15: begin r = (a >> 1) | (a & 8'h80); c = a[0]; w = 6'h1F; end
      16: r = {a[3:0], a[7:4]};
      17: r = 8'hFF;
      default: r = 0;
    endcase
    if (o >= 11 && o <= 15) v = r[7] ^ c;
    f = {h, r[7] ^ v, v, r[7], r == 0, c};
    return {r, f & w, w};
  endfunction

  task automatic drive(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic e);
    item_t it;
    logic [19:0] m;
    @(negedge clk);
    op = o; opa = a; opb = b; cin = ci; en = e;
    m = model(o, a, b, ci);
    if (e) mstat = (mstat & ~m[5:0]) | (m[11:6] & m[5:0]);
    it.op = o; it.r = m[19:12]; it.f = m[11:6]; it.w = m[5:0]; it.st = mstat;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      string rq;
      it = q.pop_front();
      rq = req_of(it.op);
      check(rq, "result", res, it.r);
      check(rq, "mask", fl_we, it.w);
      check("R11", "flags", fl_new & it.w, it.f);
      check("R12", "status", status, it.st);
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R12", "reset status", status, 0);
    rst_n = 1'b1;
    #1;
    check("R12", "status after release", status, 0);
    // R1 overflow / carry edges
    drive(0, 8'h7F, 8'h01, 0, 1);
    drive(1, 8'hFF, 8'h00, 1, 1);
    drive(1, 8'h0F, 8'h00, 1, 1);
    // R2 borrow edges
    drive(2, 8'h80, 8'h01, 0, 1);
    drive(3, 8'h00, 8'h00, 1, 1);
    drive(3, 8'h10, 8'h0F, 0, 1);
    // R3 logic keeps C and H
    drive(4, 8'hF0, 8'h0F, 0, 1);
    drive(5, 8'h80, 8'h01, 0, 1);
    drive(6, 8'hAA, 8'hAA, 0, 1);
    // R4 complement
    drive(7, 8'hFF, 8'h00, 0, 1);
    // R5 negate corners
    drive(8, 8'h00, 8'h00, 0, 1);
    drive(8, 8'h80, 8'h00, 0, 1);
    drive(8, 8'h01, 8'h00, 0, 1);
    // R6 inc/dec overflow, C preserved
    drive(0, 8'hFF, 8'h01, 0, 1);
    drive(9, 8'h7F, 8'h00, 0, 1);
    drive(10, 8'h80, 8'h00, 0, 1);
    drive(9, 8'hFF, 8'h00, 0, 1);
    // R7 R8 R9 shifts and rotates
    drive(11, 8'h81, 8'h00, 0, 1);
    drive(12, 8'h01, 8'h00, 0, 1);
    drive(13, 8'h80, 8'h00, 1, 1);
    drive(14, 8'h01, 8'h00, 1, 1);
    drive(15, 8'h81, 8'h00, 0, 1);
    // R10 quiet ops and unused codes
    drive(16, 8'h3C, 8'h00, 0, 1);
    drive(17, 8'h00, 8'h00, 0, 1);
    drive(23, 8'h55, 8'h66, 1, 1);
    // R12 hold with en low
    drive(2, 8'h00, 8'h01, 0, 0);
    drive(0, 8'h00, 8'h00, 0, 0);
    for (int i = 0; i < 3000; i++)
      drive(5'($urandom_range(0, 31)), 8'($urandom), 8'($urandom),
            1'($urandom), ($urandom_range(0, 3) != 0));
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule